// File: doc/BRIEF.md
# Configurable Pin Interrupt Detector

This block watches a vector of general-purpose input pins and turns their activity into interrupt requests. Each pin passes through a two-flop synchronizer. For every pin that is enabled both as an input and for sampling, the block updates that pin's bit in a port data register. In the same edge it decides whether the pin produced an event. The decision compares the bit's previous registered level with the freshly synchronized level, under that pin's mode settings: level sense, any-edge sense, or a single edge chosen by polarity.

Per-pin events are gated by two independent enable vectors. The results are ORed into two request outputs, A and B, each one clock cycle wide per cycle of qualifying activity. A pin enabled in both vectors drives both outputs at once. The configuration and enable vectors arrive as plain inputs from a register file elsewhere. Only the lowest `EXT_PINS` positions of the data vector are wired to pads, and the others never change.

Top module: `pin_irq_detect`

## Requirements
- R1: While `rst_n` is low, `data_o`, `irq_a_o` and `irq_b_o` are all 0, and they remain 0 in the first cycle after release.
- R2: A pin is live only when its `cfg_dir_i` bit and its `cfg_inen_i` bit are both 1. A non-live pin keeps its `data_o` bit and produces no event, whatever its pad does.
- R3: A level applied to a live pin's pad before rising edge k appears on that pin's `data_o` bit after rising edge k+2. The path is two synchronizer flops and then the data register.
- R4: Edge mode (`cfg_edge_i`=1) with `cfg_dual_i`=0: any difference between the old data bit and the new synchronized level is an event.
- R5: Edge mode with `cfg_dual_i`=1: `cfg_pol_i`=0 makes only a 0-to-1 change an event, and `cfg_pol_i`=1 makes only a 1-to-0 change an event.
- R6: Level mode (`cfg_edge_i`=0): there is an event in every cycle where the new level differs from `cfg_pol_i`. Polarity 0 is active-high and polarity 1 is active-low. `cfg_dual_i` has no effect in this mode.
- R7: `irq_a_o` is 1 in the cycle after an edge where some pin has an event and its `en_a_i` bit set. `irq_b_o` follows the same rule with `en_b_i`. Both rise in the same cycle as the corresponding `data_o` update.
- R8: Bit positions at or above `EXT_PINS` (default 15 of 16) are never sampled and stay 0.
- R9: A sample updates only the pin's own `data_o` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Asynchronous pad levels |
| cfg_dir_i | input | NPINS | 1 = pin configured as input |
| cfg_inen_i | input | NPINS | 1 = input sampling enabled |
| cfg_edge_i | input | NPINS | 1 = edge sense, 0 = level sense |
| cfg_dual_i | input | NPINS | In edge mode, 1 = single edge chosen by polarity, 0 = any change |
| cfg_pol_i | input | NPINS | Polarity: selects falling edge / active-low when 1 |
| en_a_i | input | NPINS | Per-pin enable towards request A |
| en_b_i | input | NPINS | Per-pin enable towards request B |
| data_o | output | NPINS | Port data register |
| irq_a_o | output | 1 | Request A pulse |
| irq_b_o | output | 1 | Request B pulse |

## Verification
Every cycle, the assertions check these rules:
- a non-live pin's data bit holds, and unwired positions stay zero;
- a live bit takes the previous synchronized level;
- single-edge modes never fire on the wrong direction, and level and any-change modes never miss an event;
- each request pulse traces back to an enabled event one cycle earlier.

Only the bench's scenarios can show the end-to-end behaviour: the exact three-edge latency from pad to output, the repeated pulses of a held level, and the A/B separation under random configurations.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int unsigned DEF_PINS = 16;
  localparam int unsigned DEF_EXT  = 15;

  // Event decision for one pin from its mode bits and its old/new levels.
  function automatic logic pin_event(
    input logic edge_mode,
    input logic one_edge,
    input logic pol,
    input logic old_lvl,
    input logic new_lvl
  );
    logic r;
    if (edge_mode) begin
      if (one_edge) r = pol ? (old_lvl & ~new_lvl) : (~old_lvl & new_lvl);
      else          r = old_lvl ^ new_lvl;
    end else begin
      r = new_lvl ^ pol;
    end
    return r;
  endfunction

  // Mask of pad-connected bit positions.
  function automatic logic [63:0] low_mask(input int unsigned n);
    logic [63:0] m;
    m = '0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/pin_event_eval.sv
module pin_event_eval
  import pin_irq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] dual_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] new_i,
  output logic [W-1:0] evt_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign evt_o[i] = live_i[i] &
                      pin_event(edge_i[i], dual_i[i], pol_i[i], old_i[i], new_i[i]);
  end

  // R5: rising-only pins never fire on anything but 0->1
  assert_rise_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o & edge_i & dual_i & ~pol_i & ~(new_i & ~old_i)) == '0);
  // R5: falling-only pins never fire on anything but 1->0
  assert_fall_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o & edge_i & dual_i & pol_i & ~(old_i & ~new_i)) == '0);
  // R4: a live any-change pin never misses a change
  assert_any_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i & edge_i & ~dual_i & (old_i ^ new_i) & ~evt_o) == '0);
  // R6: a live level pin fires whenever its level differs from polarity
  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i & ~edge_i & (new_i ^ pol_i) & ~evt_o) == '0);
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_a_i,
  input  logic [W-1:0] en_b_i,
  output logic         irq_a_o,
  output logic         irq_b_o
);
  logic hit_a, hit_b;
  assign hit_a = |(evt_i & en_a_i);
  assign hit_b = |(evt_i & en_b_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_a_o <= 1'b0;
      irq_b_o <= 1'b0;
    end else begin
      irq_a_o <= hit_a;
      irq_b_o <= hit_b;
    end
  end

  // R7: each request pulse comes from an enabled event one cycle earlier
  assert_a_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a_o |-> ($past(evt_i & en_a_i) != '0));
  assert_b_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b_o |-> ($past(evt_i & en_b_i) != '0));
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int unsigned NPINS    = DEF_PINS,
  parameter int unsigned EXT_PINS = DEF_EXT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] cfg_dir_i,
  input  logic [NPINS-1:0] cfg_inen_i,
  input  logic [NPINS-1:0] cfg_edge_i,
  input  logic [NPINS-1:0] cfg_dual_i,
  input  logic [NPINS-1:0] cfg_pol_i,
  input  logic [NPINS-1:0] en_a_i,
  input  logic [NPINS-1:0] en_b_i,
  output logic [NPINS-1:0] data_o,
  output logic             irq_a_o,
  output logic             irq_b_o
);
  localparam logic [63:0]      FULL_MASK = low_mask(EXT_PINS);
  localparam logic [NPINS-1:0] CONN_MASK = FULL_MASK[NPINS-1:0];

  logic [NPINS-1:0] sync_lvl;
  logic [NPINS-1:0] live;
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] data_q;

  pin_sync #(.W(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (sync_lvl)
  );

  assign live = cfg_dir_i & cfg_inen_i & CONN_MASK;

  pin_event_eval #(.W(NPINS)) u_eval (
    .clk    (clk),
    .rst_n  (rst_n),
    .live_i (live),
    .edge_i (cfg_edge_i),
    .dual_i (cfg_dual_i),
    .pol_i  (cfg_pol_i),
    .old_i  (data_q),
    .new_i  (sync_lvl),
    .evt_o  (evt)
  );

  // Only live bit positions take the new level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= (data_q & ~live) | (sync_lvl & live);
  end

  irq_merge #(.W(NPINS)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt),
    .en_a_i  (en_a_i),
    .en_b_i  (en_b_i),
    .irq_a_o (irq_a_o),
    .irq_b_o (irq_b_o)
  );

  assign data_o = data_q;

  // R2: non-live bits hold
  assert_inactive_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((data_q ^ $past(data_q)) & ~$past(live)) == '0);
  // R3: live bits take the previous synchronized level
  assert_sample_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((data_q ^ $past(sync_lvl)) & $past(live)) == '0);
  // R8: unwired positions stay zero
  assert_unwired_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_q & ~CONN_MASK) == '0);
endmodule

// File: tb/pin_irq_detect_bench.sv
module pin_irq_detect_bench;
  localparam int NP = 16;
  localparam int NE = 15;
  localparam logic [NP-1:0] CONN = NP'((32'd1 << NE) - 32'd1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [NP-1:0] pin, dir, inen, edg, dual, pol, ena, enb;
  wire  [NP-1:0] data;
  wire           irq_a, irq_b;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  logic [NP-1:0] m_s1, m_s2, m_data;
  logic          m_a, m_b;

  pin_irq_detect u_pin_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pin),
    .cfg_dir_i(dir), .cfg_inen_i(inen), .cfg_edge_i(edg),
    .cfg_dual_i(dual), .cfg_pol_i(pol), .en_a_i(ena), .en_b_i(enb),
    .data_o(data), .irq_a_o(irq_a), .irq_b_o(irq_b)
  );

  // Expected event from the mode table of R4, R5, R6.
  function automatic logic want(logic e, logic d, logic p, logic o, logic n);
    logic r;
    case ({e, d, p})
      3'b000, 3'b010: r = n;
      3'b001, 3'b011: r = ~n;
      3'b100, 3'b101: r = (o != n);
      3'b110:         r = n && !o;
      default:        r = o && !n;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply current inputs across one rising edge and compare.
  task automatic step();
    logic [NP-1:0] live, evt;
    live = dir & inen & CONN;
    for (int i = 0; i < NP; i++)
      evt[i] = live[i] & want(edg[i], dual[i], pol[i], m_data[i], m_s2[i]);
    m_a    = |(evt & ena);
    m_b    = |(evt & enb);
    m_data = (m_data & ~live) | (m_s2 & live);
    m_s2   = m_s1;
    m_s1   = pin;
    @(posedge clk);
    @(negedge clk);
    check("R2 R3 R9 data", data, m_data);
    check("R4 R5 R6 R7 irq_a", NP'(irq_a), NP'(m_a));
    check("R4 R5 R6 R7 irq_b", NP'(irq_b), NP'(m_b));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    pin = '0; dir = '0; inen = '0; edg = '0; dual = '0; pol = '0; ena = '0; enb = '0;
    m_s1 = '0; m_s2 = '0; m_data = '0; m_a = 1'b0; m_b = 1'b0;
    repeat (3) @(negedge clk);
    pin = '1; dir = '1; inen = '1; ena = '1; enb = '1;
    @(negedge clk);
    check("R1 data in reset", data, '0);
    check("R1 irq in reset", NP'({irq_a, irq_b}), '0);
    pin = '0; dir = '0; inen = '0; ena = '0; enb = '0;
    rst_n = 1'b1;
    step();
    check("R1 after release", NP'({irq_a, irq_b}), '0);

    // R4: any-change edge mode on pin 3, routed to A only
    dir = '1; inen = '1; edg = '1; dual = '0; pol = '0; ena = '1; enb = '0;
    repeat (3) step();
    pin[3] = 1'b1;
    step(); step();
    check("R3 not yet visible", NP'(data[3]), '0);
    step();
    check("R3 visible after third edge", NP'(data[3]), NP'(1));
    check("R4 rise fires A", NP'(irq_a), NP'(1));
    step();
    check("R7 one-cycle pulse", NP'(irq_a), '0);
    pin[3] = 1'b0;
    repeat (3) step();
    check("R4 fall fires A", NP'(irq_a), NP'(1));
    check("R7 B masked", NP'(irq_b), '0);

    // R5: single-edge modes on pin 5, routed to B only
    dual = '1; pol = '0; ena = '0; enb = 16'h0020;
    pin[5] = 1'b1; repeat (3) step();
    check("R5 rising selected", NP'(irq_b), NP'(1));
    pin[5] = 1'b0; repeat (3) step();
    check("R5 falling ignored", NP'(irq_b), '0);
    pol = 16'h0020;
    pin[5] = 1'b1; repeat (3) step();
    check("R5 rising ignored pol1", NP'(irq_b), '0);
    pin[5] = 1'b0; repeat (3) step();
    check("R5 falling selected pol1", NP'(irq_b), NP'(1));

    // R6: level mode, active-low on pin 7, repeats while held
    edg = '0; dual = '1; pol = '1; ena = 16'h0080; enb = 16'h0080; pin = '1;
    repeat (4) step();
    pin[7] = 1'b0;
    repeat (5) step();
    check("R6 held low repeats", NP'({irq_a, irq_b}), NP'(3));

    // R8: position 15 never sampled
    pol = '0; pin = '1; repeat (4) step();
    check("R8 unwired bit", NP'(data[15]), '0);

    // R2: pin 2 input but sampling disabled
    inen[2] = 1'b0; pin[2] = 1'b0; repeat (4) step();
    check("R2 held bit", NP'(data[2]), NP'(1));
    dir[2] = 1'b0; inen[2] = 1'b1; pin[2] = 1'b0; repeat (4) step();
    check("R2 output pin held", NP'(data[2]), NP'(1));

    // Random phase
    for (int blk = 0; blk < 120; blk++) begin
      dir  = NP'($urandom) | NP'($urandom);
      inen = NP'($urandom) | NP'($urandom);
      edg  = NP'($urandom);
      dual = NP'($urandom);
      pol  = NP'($urandom);
      ena  = NP'($urandom) & NP'($urandom);
      enb  = NP'($urandom) & NP'($urandom);
      for (int c = 0; c < 12; c++) begin
        if (($urandom % 3) == 0) pin = pin ^ (NP'($urandom) & NP'($urandom));
        step();
      end
    end
    summary();
  end
endmodule